// File: doc/BRIEF.md
# GPIO Change-Detect Interrupt Logic

This block raises the interrupt of a 16-pin port expander. The pins are grouped as two 8-bit ports. Each pin level passes through a two-flop synchroniser. For every pin that is configured as an input, the block compares the synchronised level with a per-port snapshot. A pin whose level differs from the snapshot becomes pending. The interrupt line is open-drain, so the block drives it through a pull-low enable that is high while any unmasked pin is pending.

When a port is read over the serial interface, that port receives a single-cycle acknowledge strobe. The strobe copies the current synchronised levels into the port's snapshot, which clears the port's pending pins. A pin can also be switched into latch mode. In latch mode, the first difference captures the pin level and holds both the pending bit and the captured value until the port is read, even if the pin goes back to its earlier level.

Top module: `gpio_chg_irq`

## Requirements
- R1: A rising or falling change on an input pin (dir bit = 1) sets that pin's `status_o` bit and `irq_pull_o`. Both outputs change two clock edges after the pin changes, because of the synchroniser.
- R2: A pin whose direction bit is 0 (output) never sets its status bit and never raises the interrupt.
- R3: A non-latched input pin that returns to its snapshot level stops being pending without any read.
- R4: A one-cycle pulse on `rd_ack_i[p]` loads port p's snapshot with the current synchronised levels. From the next cycle, that port's non-latched pins are no longer pending and its latched pins are released.
- R5: A pin change that happens after a clear is detected again and sets the pin pending again.
- R6: For an input pin in latch mode (latch bit = 1), a difference sets the status bit and captures the level. The status bit and `in_val_o` keep the captured value until the port is read, even if the pin reverts.
- R7: If a pin is switched from output to input while its level differs from the port snapshot, it becomes pending.
- R8: Port 0 covers pins 7..0 and port 1 covers pins 15..8. A read strobe for one port leaves the other port's snapshot and pending bits unchanged.
- R9: A mask bit of 1 removes that pin from `irq_pull_o`, but the pin's status bit is still set.
- R10: `irq_pull_o` is 1 exactly when at least one unmasked status bit is 1.
- R11: After a synchronous active-low reset with all pins at 0, the snapshots are 0 and `status_o`, `in_val_o` and `irq_pull_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 16 | Raw pin levels |
| dir_in_i | input | 16 | 1 = pin is an input |
| latch_en_i | input | 16 | 1 = pin uses latch mode |
| mask_i | input | 16 | 1 = pin excluded from the interrupt |
| rd_ack_i | input | 2 | One-cycle read-acknowledge strobe per port |
| irq_pull_o | output | 1 | Pull-low enable for the open-drain interrupt line |
| status_o | output | 16 | Per-pin pending bits |
| in_val_o | output | 16 | Effective input value per pin (captured value for a latched pending pin) |

## Verification
The bench goes after the following corner cases:
- **Pin reverts without a read.** A design that keeps the pending bit set would leave the line pulled low.
- **Falling change right after a clear.** A design that arms detection only on rising edges, or that never re-arms, would miss it.
- **Output pin toggling, then becoming an input.** A design that compared against live levels, or that updated the snapshot while the pin was an output, would either fire on the output toggle or miss the false interrupt that is required when the pin turns into an input.
- **Read on the wrong port, a masked pin, and a latched pin that reverts.** These expose a shared snapshot, a mask that also hides status, and a latch that follows the pin instead of holding.

// File: rtl/gpio_irq_pkg.sv
// Package: shared sizing constants for the change-detect interrupt logic.
// Assumes: all pins are grouped into equal-width ports.
package gpio_irq_pkg;
    localparam int unsigned GPIO_PORT_W    = 8;
    localparam int unsigned GPIO_PORTS     = 2;
    localparam int unsigned GPIO_SYNC_DEPTH = 2;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Multi-stage synchroniser for raw pin levels.
// Assumes: the pins are asynchronous to clk, and a reset value of 0 matches
// the pin levels held during reset.
module gpio_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift raw levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= raw_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_chg.sv
// Module: gpio_port_chg
// Change detection for one port. It holds a snapshot of the pin levels and
// per-pin latch state, and releases both on the port's read strobe.
// Assumes: sync_i is already synchronised, and rd_ack_i lasts one cycle.
module gpio_port_chg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] dir_in_i,
    input  logic [W-1:0] latch_en_i,
    input  logic         rd_ack_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] in_val_o
);
    logic [W-1:0] snap_q;
    logic [W-1:0] lpend_q;
    logic [W-1:0] lval_q;
    logic [W-1:0] diff;

    assign diff = sync_i ^ snap_q;

    // Snapshot register: reloaded only on a read of this port.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap_q <= '0;
        else if (rd_ack_i) snap_q <= sync_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        // Latch state: capture the first difference, release on a read or when latch mode is off.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lpend_q[i] <= 1'b0;
                lval_q[i]  <= 1'b0;
            end else if (rd_ack_i || !latch_en_i[i]) begin
                lpend_q[i] <= 1'b0;
            end else if (dir_in_i[i] && diff[i] && !lpend_q[i]) begin
                lpend_q[i] <= 1'b1;
                lval_q[i]  <= sync_i[i];
            end
        end

        // Pending: input pins only; a latched pin uses its held flag.
        always_comb begin
            if (!dir_in_i[i])       pend_o[i] = 1'b0;
            else if (latch_en_i[i]) pend_o[i] = lpend_q[i] | diff[i];
            else                    pend_o[i] = diff[i];
        end

        // Effective value: the captured level while a latched event is held.
        assign in_val_o[i] = (latch_en_i[i] && lpend_q[i]) ? lval_q[i] : sync_i[i];
    end

    // R4
    // latch_release_chk
    latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_i |=> (lpend_q == '0));

    // R8
    // snap_hold_chk
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack_i |=> $stable(snap_q));

    // R6
    // latch_keep_chk
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ack_i && (lpend_q & latch_en_i) != '0) |=>
            ((lpend_q & $past(lpend_q & latch_en_i)) == $past(lpend_q & latch_en_i)));
endmodule

// File: rtl/gpio_chg_irq.sv
// Module: gpio_chg_irq
// Top level: synchronises the pins, runs change detection per port, and
// combines the unmasked pending bits into the open-drain pull-low enable.
// Assumes: the port count times the port width equals the pin count.
module gpio_chg_irq
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PORT_W     = GPIO_PORT_W,
    parameter int unsigned PORTS      = GPIO_PORTS,
    parameter int unsigned SYNC_DEPTH = GPIO_SYNC_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PORT_W*PORTS-1:0]  pin_i,
    input  logic [PORT_W*PORTS-1:0]  dir_in_i,
    input  logic [PORT_W*PORTS-1:0]  latch_en_i,
    input  logic [PORT_W*PORTS-1:0]  mask_i,
    input  logic [PORTS-1:0]         rd_ack_i,
    output logic                     irq_pull_o,
    output logic [PORT_W*PORTS-1:0]  status_o,
    output logic [PORT_W*PORTS-1:0]  in_val_o
);
    localparam int unsigned NPINS = PORT_W * PORTS;

    logic [NPINS-1:0] pin_sync;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_i),
        .sync_o (pin_sync)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        gpio_port_chg #(.W(PORT_W)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_i     (pin_sync[p*PORT_W +: PORT_W]),
            .dir_in_i   (dir_in_i[p*PORT_W +: PORT_W]),
            .latch_en_i (latch_en_i[p*PORT_W +: PORT_W]),
            .rd_ack_i   (rd_ack_i[p]),
            .pend_o     (status_o[p*PORT_W +: PORT_W]),
            .in_val_o   (in_val_o[p*PORT_W +: PORT_W])
        );
    end

    // Interrupt drive: any unmasked pending pin pulls the line low.
    assign irq_pull_o = |(status_o & ~mask_i);

    // R2
    // out_pin_quiet_chk
    out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~dir_in_i) == '0);

    // R10
    // irq_source_chk
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_o |-> ((status_o & ~mask_i & dir_in_i) != '0));
endmodule

// File: tb/sim_gpio_chg_irq.sv
module sim_gpio_chg_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_i = '0;
    logic [15:0] dir_in_i = 16'hFFFF;
    logic [15:0] latch_en_i = '0;
    logic [15:0] mask_i = '0;
    logic [1:0]  rd_ack_i = '0;
    logic        irq_pull_o;
    logic [15:0] status_o;
    logic [15:0] in_val_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic        irq;
        logic [15:0] st;
        logic [15:0] iv;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    gpio_chg_irq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .dir_in_i   (dir_in_i),
        .latch_en_i (latch_en_i),
        .mask_i     (mask_i),
        .rd_ack_i   (rd_ack_i),
        .irq_pull_o (irq_pull_o),
        .status_o   (status_o),
        .in_val_o   (in_val_o)
    );

    // Driver side: queue one expected result to be compared by the monitor.
    task automatic expect_out(input logic irq, input logic [15:0] st,
                              input logic [15:0] iv, input string tag);
        exp_t e;
        e.irq = irq;
        e.st  = st;
        e.iv  = iv;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Let a pin change pass the synchroniser, then stop at a negative edge.
    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // One-cycle read strobe, then stop at the next negative edge.
    task automatic rd_port(input logic [1:0] which);
        @(negedge clk);
        rd_ack_i = which;
        @(negedge clk);
        rd_ack_i = '0;
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations just after each negative edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (irq_pull_o !== e.irq || status_o !== e.st || in_val_o !== e.iv) begin
                    fails++;
                    $display("FAIL %s: irq=%0b st=%h iv=%h expected irq=%0b st=%h iv=%h",
                             e.tag, irq_pull_o, status_o, in_val_o, e.irq, e.st, e.iv);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b0, 16'h0000, 16'h0000, "R11 reset state");
        @(negedge clk);

        pin_i[3] = 1'b1; settle();
        expect_out(1'b1, 16'h0008, 16'h0008, "R1 rising change");
        @(negedge clk);

        pin_i[3] = 1'b0; settle();
        expect_out(1'b0, 16'h0000, 16'h0000, "R3 revert clears");
        @(negedge clk);

        pin_i[3] = 1'b1; settle();
        rd_port(2'b01);
        expect_out(1'b0, 16'h0000, 16'h0008, "R4 read clears port0");
        @(negedge clk);

        pin_i[3] = 1'b0; settle();
        expect_out(1'b1, 16'h0008, 16'h0000, "R5 falling after clear");
        rd_port(2'b01);
        expect_out(1'b0, 16'h0000, 16'h0000, "R4 second read");
        @(negedge clk);

        dir_in_i[12] = 1'b0; pin_i[12] = 1'b1; settle();
        expect_out(1'b0, 16'h0000, 16'h1000, "R2 output pin ignored");
        @(negedge clk);

        dir_in_i[12] = 1'b1; @(negedge clk);
        expect_out(1'b1, 16'h1000, 16'h1000, "R7 output to input mismatch");
        rd_port(2'b01);
        expect_out(1'b1, 16'h1000, 16'h1000, "R8 port0 read leaves port1");
        rd_port(2'b10);
        expect_out(1'b0, 16'h0000, 16'h1000, "R4 port1 read");
        @(negedge clk);

        mask_i[5] = 1'b1; pin_i[5] = 1'b1; settle();
        expect_out(1'b0, 16'h0020, 16'h1020, "R9 masked pin status only");
        rd_port(2'b01);
        mask_i[5] = 1'b0;
        @(negedge clk);
        expect_out(1'b0, 16'h0000, 16'h1020, "R10 no pending no pull");
        @(negedge clk);

        latch_en_i[9] = 1'b1; pin_i[9] = 1'b1; settle();
        expect_out(1'b1, 16'h0200, 16'h1220, "R6 latch capture");
        @(negedge clk);
        pin_i[9] = 1'b0; settle();
        expect_out(1'b1, 16'h0200, 16'h1220, "R6 latch holds after revert");
        rd_port(2'b10);
        expect_out(1'b0, 16'h0000, 16'h1020, "R6 latch released by read");
        @(negedge clk);

        pin_i[9] = 1'b1; settle();
        expect_out(1'b1, 16'h0200, 16'h1220, "R5 latch re-detect");
        @(negedge clk);
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule